// File: doc/BRIEF.md
# Dual-Mode Seven-Segment Display Driver

This block drives a four-digit multiplexed seven-segment display whose segment and digit-select lines are both active low. It has two modes, and the mode input picks between them. In number mode it decodes a 4-bit value into a hexadecimal glyph and lights only the leftmost digit. In message mode it ignores the value and scans the word "FAIL" across the four digits. Each scan step lights one digit and is triggered by a refresh-tick enable from a divider elsewhere in the chip.

One clocked process owns both output buses, and both modes share it. Each output has a single driver and no combinational loop can form. A small scan controller keeps the current digit position. A combinational frame selector works out the next segment and select pattern. The output register loads that pattern on the next rising edge. Results therefore appear one clock after the inputs that cause them.

Top module: `dual_seg_driver`

## Requirements
- R1: While reset is high on a rising edge, the outputs become blank after that edge: digit select 4'b1111 and segments 7'b1111111.
- R2: In number mode (fail input low), the digit select is 4'b0111 one clock later, so only the leftmost digit is enabled. The segments show the glyph of the value input sampled on that edge.
- R3: Hex glyphs are active low, ordered {g,f,e,d,c,b,a}: 0=7'h40, 1=7'h79, 2=7'h24, 3=7'h30, 4=7'h19, 5=7'h12, 6=7'h02, 7=7'h78, 8=7'h00, 9=7'h10, A=7'h08, b=7'h03, C=7'h46, d=7'h21, E=7'h06, F=7'h0E.
- R4: In message mode, each edge where the tick input is high loads one digit of the message. The digits come in this order: F=7'h0E with select 4'b0111, A=7'h08 with 4'b1011, I=7'h79 with 4'b1101, then L=7'h47 with 4'b1110.
- R5: After the rightmost digit (L) has been shown, the next tick in message mode shows F on the leftmost digit again.
- R6: In message mode, an edge with the tick input low leaves both output buses unchanged.
- R7: While the fail input is low, the scan position stays at the leftmost digit. The first tick after the fail input goes high therefore always shows F on the leftmost digit, even if an earlier scan was cut off mid-word.
- R8: Exactly one digit-select bit is low whenever the select bus is not 4'b1111. When the select bus is 4'b1111, the segments are 7'b1111111.
- R9: In message mode, changing the value input has no effect on either output bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hex_val | input | 4 | Value shown in number mode |
| fail_mode | input | 1 | High selects message mode, low selects number mode |
| refresh_tick | input | 1 | Scan-step enable for message mode |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |
| dig_n | output | 4 | Active-low digit select, bit 3 is leftmost |

## Verification
The assertions check four things on every clock: the leftmost-only select in number mode, the select position that follows each message tick, the hold on edges without a tick, and the single-low-bit rule for the select bus. They also check the scan position: it wraps after the rightmost digit and stays parked while the fail input is low. Only the bench scenarios can show the glyph content. Those scenarios cover all sixteen hex patterns, the four letter patterns in order, the restart after a cut-off scan, and the fact that the value input is ignored in message mode.

// File: rtl/seg_pkg.sv
package seg_pkg;

  localparam int SEG_W = 7;
  localparam int VAL_W = 4;

  typedef logic [SEG_W-1:0] glyph_t;

  localparam glyph_t GLYPH_BLANK = 7'h7F;

  // Active-low hex decode, bit order {g,f,e,d,c,b,a}
  function automatic glyph_t hex_glyph(input logic [VAL_W-1:0] v);
    glyph_t g;
    case (v)
      4'h0: g = 7'h40;
      4'h1: g = 7'h79;
      4'h2: g = 7'h24;
      4'h3: g = 7'h30;
      4'h4: g = 7'h19;
      4'h5: g = 7'h12;
      4'h6: g = 7'h02;
      4'h7: g = 7'h78;
      4'h8: g = 7'h00;
      4'h9: g = 7'h10;
      4'hA: g = 7'h08;
      4'hB: g = 7'h03;
      4'hC: g = 7'h46;
      4'hD: g = 7'h21;
      4'hE: g = 7'h06;
      default: g = 7'h0E;
    endcase
    return g;
  endfunction

  // Letters of the failure word by scan position (0 = leftmost)
  function automatic glyph_t msg_glyph(input int unsigned pos);
    glyph_t g;
    case (pos)
      0: g = 7'h0E;
      1: g = 7'h08;
      2: g = 7'h79;
      3: g = 7'h47;
      default: g = GLYPH_BLANK;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl #(
  parameter int DIGITS = 4,
  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fail_mode,
  input  logic             refresh_tick,
  output logic [IDX_W-1:0] scan_idx,
  output logic             scan_step
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DIGITS - 1);

  assign scan_step = fail_mode && refresh_tick;

  always_ff @(posedge clk) begin
    if (rst || !fail_mode) begin
      scan_idx <= '0;
    end else if (scan_step) begin
      scan_idx <= (scan_idx == LAST) ? '0 : scan_idx + 1'b1;
    end
  end

endmodule

// File: rtl/seg_frame_sel.sv
module seg_frame_sel
  import seg_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic             fail_mode,
  input  logic             scan_step,
  input  logic [IDX_W-1:0] scan_idx,
  input  logic [VAL_W-1:0] hex_val,
  output glyph_t           nxt_seg,
  output logic [DIGITS-1:0] nxt_dig,
  output logic             frame_load
);

  logic [DIGITS-1:0] msg_dig;
  logic [DIGITS-1:0] num_dig;

  // Select bit DIGITS-1 is the leftmost digit, position 0
  for (genvar i = 0; i < DIGITS; i++) begin : g_sel
    assign msg_dig[i] = (scan_idx != IDX_W'(DIGITS - 1 - i));
    assign num_dig[i] = (i != DIGITS - 1);
  end

  assign frame_load = !fail_mode || scan_step;

  always_comb begin
    if (fail_mode) begin
      nxt_seg = msg_glyph(int'(scan_idx));
      nxt_dig = msg_dig;
    end else begin
      nxt_seg = hex_glyph(hex_val);
      nxt_dig = num_dig;
    end
  end

endmodule

// File: rtl/dual_seg_driver.sv
module dual_seg_driver
  import seg_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VAL_W-1:0]  hex_val,
  input  logic              fail_mode,
  input  logic              refresh_tick,
  output logic [SEG_W-1:0]  seg_n,
  output logic [DIGITS-1:0] dig_n
);

  logic [IDX_W-1:0]  scan_idx;
  logic              scan_step;
  glyph_t            nxt_seg;
  logic [DIGITS-1:0] nxt_dig;
  logic              frame_load;

  seg_scan_ctrl #(.DIGITS(DIGITS)) u_scan (
    .clk          (clk),
    .rst          (rst),
    .fail_mode    (fail_mode),
    .refresh_tick (refresh_tick),
    .scan_idx     (scan_idx),
    .scan_step    (scan_step)
  );

  seg_frame_sel #(.DIGITS(DIGITS)) u_frame (
    .fail_mode  (fail_mode),
    .scan_step  (scan_step),
    .scan_idx   (scan_idx),
    .hex_val    (hex_val),
    .nxt_seg    (nxt_seg),
    .nxt_dig    (nxt_dig),
    .frame_load (frame_load)
  );

  // The only process that drives the display pins, shared by both modes
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n <= GLYPH_BLANK;
      dig_n <= '1;
    end else if (frame_load) begin
      seg_n <= nxt_seg;
      dig_n <= nxt_dig;
    end
  end

endmodule

// File: rtl/dual_seg_driver_chk.sv
module dual_seg_driver_chk #(
  parameter int DIGITS = 4,
  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              fail_mode,
  input logic              refresh_tick,
  input logic [6:0]        seg_n,
  input logic [DIGITS-1:0] dig_n,
  input logic [IDX_W-1:0]  scan_idx,
  input logic              scan_step
);

  localparam logic [DIGITS-1:0] LEFT_ONLY = ~(DIGITS'(1) << (DIGITS - 1));

  p_reset_blank_r1: assert property (@(posedge clk)
    rst |=> (rst || (dig_n == '1 && seg_n == 7'h7F)));

  p_number_left_r2: assert property (@(posedge clk) disable iff (rst)
    !fail_mode |=> dig_n == LEFT_ONLY);

  p_msg_select_r4: assert property (@(posedge clk) disable iff (rst)
    (fail_mode && refresh_tick) |=>
      dig_n == ~((DIGITS'(1) << (DIGITS - 1)) >> $past(scan_idx)));

  p_scan_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (scan_step && scan_idx == IDX_W'(DIGITS - 1)) |=> scan_idx == '0);

  p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (rst)
    (fail_mode && !refresh_tick) |=> ($stable(dig_n) && $stable(seg_n)));

  p_scan_parked_r7: assert property (@(posedge clk) disable iff (rst)
    !fail_mode |=> scan_idx == '0);

  p_one_digit_r8: assert property (@(posedge clk) disable iff (rst)
    (dig_n != '1) |-> $countones(~dig_n) == 1);

  p_blank_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    (dig_n == '1) |-> seg_n == 7'h7F);

endmodule

bind dual_seg_driver dual_seg_driver_chk #(.DIGITS(DIGITS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .fail_mode    (fail_mode),
  .refresh_tick (refresh_tick),
  .seg_n        (seg_n),
  .dig_n        (dig_n),
  .scan_idx     (scan_idx),
  .scan_step    (scan_step)
);

// File: tb/dual_seg_driver_test.sv
`timescale 1ns/1ps
module dual_seg_driver_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] hex_val = 4'h0;
  logic       fail_mode = 1'b0;
  logic       refresh_tick = 1'b0;
  logic [6:0] seg_n;
  logic [3:0] dig_n;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dual_seg_driver uut (
    .clk(clk), .rst(rst), .hex_val(hex_val), .fail_mode(fail_mode),
    .refresh_tick(refresh_tick), .seg_n(seg_n), .dig_n(dig_n)
  );

  // Expected glyphs written from the requirement tables
  function automatic logic [6:0] ref_hex(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78,
                           7'h00, 7'h10, 7'h08, 7'h03, 7'h46, 7'h21, 7'h06, 7'h0E};
    return t[v];
  endfunction

  function automatic logic [6:0] ref_letter(input int p);
    logic [6:0] t [4] = '{7'h0E, 7'h08, 7'h79, 7'h47};
    return t[p % 4];
  endfunction

  function automatic logic [3:0] ref_sel(input int p);
    logic [3:0] t [4] = '{4'b0111, 4'b1011, 4'b1101, 4'b1110};
    return t[p % 4];
  endfunction

  // Advance one edge, then sample 1 ns later
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [6:0] es, input logic [3:0] ed);
    total++;
    if (seg_n !== es || dig_n !== ed) begin
      bad++;
      $display("FAIL %s: seg=%h dig=%b expected seg=%h dig=%b", req, seg_n, dig_n, es, ed);
    end
    total++;
    if (dig_n !== 4'b1111 && $countones(~dig_n) != 1) begin
      bad++;
      $display("FAIL R8: dig=%b expected one low bit", dig_n);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step();
    step();
    check("R1", 7'h7F, 4'b1111);
    rst = 1'b0;
  endtask

  task automatic t_number();
    fail_mode = 1'b0;
    refresh_tick = 1'b0;
    for (int v = 0; v < 16; v++) begin
      hex_val = 4'(v);
      step();
      check("R3", ref_hex(4'(v)), 4'b0111);
    end
    hex_val = 4'h5;
    refresh_tick = 1'b1;
    step();
    check("R2", ref_hex(4'h5), 4'b0111);
    refresh_tick = 1'b0;
  endtask

  task automatic t_message();
    hex_val = 4'h9;
    step();
    fail_mode = 1'b1;
    step();
    check("R6", ref_hex(4'h9), 4'b0111);
    for (int k = 0; k < 9; k++) begin
      refresh_tick = 1'b1;
      hex_val = 4'(k);
      step();
      refresh_tick = 1'b0;
      check(k < 4 ? "R4" : "R5", ref_letter(k), ref_sel(k));
      step();
      check("R6", ref_letter(k), ref_sel(k));
    end
  endtask

  task automatic t_value_ignored();
    for (int v = 0; v < 4; v++) begin
      hex_val = 4'(v * 5);
      step();
      check("R9", ref_letter(0), ref_sel(0));
    end
  endtask

  task automatic t_restart();
    refresh_tick = 1'b1;
    step();
    check("R4", ref_letter(1), ref_sel(1));
    refresh_tick = 1'b0;
    fail_mode = 1'b0;
    hex_val = 4'hC;
    step();
    check("R2", ref_hex(4'hC), 4'b0111);
    fail_mode = 1'b1;
    step();
    check("R6", ref_hex(4'hC), 4'b0111);
    refresh_tick = 1'b1;
    step();
    check("R7", ref_letter(0), ref_sel(0));
    step();
    check("R7", ref_letter(1), ref_sel(1));
    refresh_tick = 1'b0;
    rst = 1'b1;
    step();
    check("R1", 7'h7F, 4'b1111);
    rst = 1'b0;
    refresh_tick = 1'b1;
    step();
    check("R7", ref_letter(0), ref_sel(0));
    refresh_tick = 1'b0;
  endtask

  initial begin
    #1;
    t_reset();
    t_number();
    t_message();
    t_value_ignored();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule